// File: doc/BRIEF.md
# Receive Block-Sequence Checker with Error Recovery

This block watches the stream of classified receive blocks of a 64b/66b link, one block per valid cycle. It follows a five-state machine (idle, start, data, terminate, error) and decides for each packet whether its framing held from start block to terminate block. A packet whose framing came into doubt is dropped and is never repaired. A clean packet is reported with a one-cycle accept pulse. A packet cut short by an error is reported with a one-cycle discard pulse. On every cycle the machine sits in the error state, a flag tells downstream logic to overwrite that block with an error control block.

Leaving the error state is the main design issue. The relaxed policy lets the machine resume on an idle, data or terminate block without waiting for a clean idle. That matters when back-to-back packets leave no idle block between them. A start block out of the error state is taken only once the error has lasted two blocks, so that a few bit flips cannot turn a damaged stream into a forged packet start. A strict policy, where only an idle block ends the error state, can be chosen by parameter. A second parameter decides whether a packet is accepted on its terminate block, or only once the following block shows that the packet was closed cleanly.

Top module: `blkseq_chk`

## Requirements
- R1: After reset, `state_o` is 4 (error), `err_blk_o` is 1, and `accept_o` and `discard_o` are 0.
- R2: Block codes are idle=0, start=1, data=2, terminate=3, and any other value is undecodable. State codes are idle=0, start=1, data=2, terminate=3, error=4. Outside the error state, the legal moves are idle to idle or start, start to data, data to data or terminate, and terminate to idle or start. Every other block moves the machine to error.
- R3: `err_blk_o` is 1 exactly on the cycles when `state_o` is 4.
- R4: With RELAXED_EXIT=1, an idle, data or terminate block in the error state moves the machine straight to idle, data or terminate.
- R5: With RELAXED_EXIT=1, a start block moves the machine from error to start only if the previous valid block also left the machine in error. Otherwise the machine stays in error. The first block after reset counts as a fresh entry into error.
- R6: With RELAXED_EXIT=0, only an idle block leaves the error state. Start, data, terminate and undecodable blocks keep the machine in error.
- R7: With TAIL_STRICT=0, `accept_o` pulses for one cycle, together with `state_o`=3, when a terminate block closes a packet that has had no error since its start block.
- R8: `discard_o` pulses for one cycle on the first block at which a packet in progress enters the error state. Further blocks in error do not pulse it again.
- R9: A packet reached through the error state (error then data, or the sequences terminate/idle/data, error, start, data) is never accepted. Its terminate block gives no accept pulse.
- R10: A start block directly after a terminate block is legal, and both of the back-to-back packets are accepted.
- R11: While `blk_vld_i` is 0, the state holds, whatever the code input, and neither pulse is asserted.
- R12: With TAIL_STRICT=1, a clean packet is accepted on the block after its terminate block, and only if that block is idle or start. If that block sends the machine to error, `discard_o` pulses instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_vld_i | input | 1 | A classified block is present this cycle |
| blk_code_i | input | CODE_W | Block type code |
| state_o | output | 3 | Current sequence state |
| err_blk_o | output | 1 | Current block is to be replaced by an error block |
| accept_o | output | 1 | One-cycle pulse: clean packet completed |
| discard_o | output | 1 | One-cycle pulse: packet in progress dropped |

## Verification
The bench targets forged starts: an error followed at once by a start block, after a terminate, an idle or a data block. A design that let error go straight to start would accept a packet at the following terminate block. It compares this with a double error, after which a start must be taken; a qualifier that looked at the wrong history would block good packets here. Recovery on data and terminate blocks is run against the strict instance, which must stay in error. Back-to-back packets with no idle between them check that terminate-to-start is legal. The tail option is checked both ways: a late accept, and a discard in place of it when the packet's terminate block is followed by an error.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

   // Sequence states; the numeric codes are visible on state_o.
   typedef enum logic [2:0] {
      ST_Z = 3'd0,
      ST_S = 3'd1,
      ST_D = 3'd2,
      ST_T = 3'd3,
      ST_E = 3'd4
   } seq_state_t;

   // Decoded block kind.
   typedef enum logic [2:0] {
      K_IDLE,
      K_START,
      K_DATA,
      K_TERM,
      K_BAD
   } blk_kind_t;

   // Block type code values on the input.
   localparam int BK_IDLE  = 0;
   localparam int BK_START = 1;
   localparam int BK_DATA  = 2;
   localparam int BK_TERM  = 3;

   localparam int STATE_W  = 3;

endpackage

// File: rtl/blkseq_next.sv
module blkseq_next
   import blkseq_pkg::*;
#(
   parameter int CODE_W       = 3,
   parameter bit RELAXED_EXIT = 1'b1
) (
   input  seq_state_t        cur_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              e_twice_i,
   output seq_state_t        nxt_o
);

   localparam logic [CODE_W-1:0] C_IDLE  = CODE_W'(BK_IDLE);
   localparam logic [CODE_W-1:0] C_START = CODE_W'(BK_START);
   localparam logic [CODE_W-1:0] C_DATA  = CODE_W'(BK_DATA);
   localparam logic [CODE_W-1:0] C_TERM  = CODE_W'(BK_TERM);

   blk_kind_t  kind;
   seq_state_t from_e;

   always_comb begin
      if (code_i == C_IDLE)       kind = K_IDLE;
      else if (code_i == C_START) kind = K_START;
      else if (code_i == C_DATA)  kind = K_DATA;
      else if (code_i == C_TERM)  kind = K_TERM;
      else                        kind = K_BAD;
   end

   // Exit policy out of the error state.
   generate
      if (RELAXED_EXIT) begin : g_relaxed
         always_comb begin
            case (kind)
               K_IDLE:  from_e = ST_Z;
               K_DATA:  from_e = ST_D;
               K_TERM:  from_e = ST_T;
               K_START: from_e = e_twice_i ? ST_S : ST_E;
               default: from_e = ST_E;
            endcase
         end
      end else begin : g_strict
         always_comb from_e = (kind == K_IDLE) ? ST_Z : ST_E;
      end
   endgenerate

   always_comb begin
      nxt_o = ST_E;
      case (cur_i)
         ST_Z: begin
            if (kind == K_IDLE)       nxt_o = ST_Z;
            else if (kind == K_START) nxt_o = ST_S;
         end
         ST_S: begin
            if (kind == K_DATA) nxt_o = ST_D;
         end
         ST_D: begin
            if (kind == K_DATA)      nxt_o = ST_D;
            else if (kind == K_TERM) nxt_o = ST_T;
         end
         ST_T: begin
            if (kind == K_IDLE)       nxt_o = ST_Z;
            else if (kind == K_START) nxt_o = ST_S;
         end
         ST_E:    nxt_o = from_e;
         default: nxt_o = ST_E;
      endcase
   end

endmodule

// File: rtl/blkseq_pkt.sv
module blkseq_pkt
   import blkseq_pkg::*;
#(
   parameter bit TAIL_STRICT = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       vld_i,
   input  seq_state_t cur_i,
   input  seq_state_t nxt_i,
   output logic       accept_o,
   output logic       discard_o
);

   logic pkt_ok_q, pkt_ok_d;
   logic pend_q, pend_d;
   logic acc_d, disc_d;
   logic enter_e, done;

   assign enter_e = (nxt_i == ST_E) && (cur_i != ST_E);
   assign done    = (cur_i == ST_D) && pkt_ok_q && (nxt_i == ST_T);

   // A packet stays good only while it moves start -> data.
   always_comb begin
      if (nxt_i == ST_S)      pkt_ok_d = 1'b1;
      else if (nxt_i == ST_D) pkt_ok_d = pkt_ok_q;
      else                    pkt_ok_d = 1'b0;
   end

   generate
      if (TAIL_STRICT) begin : g_tail_strict
         assign pend_d = done;
         assign acc_d  = pend_q && ((nxt_i == ST_Z) || (nxt_i == ST_S));
         assign disc_d = enter_e && (pkt_ok_q || pend_q);
      end else begin : g_tail_lenient
         assign pend_d = 1'b0;
         assign acc_d  = done;
         assign disc_d = enter_e && pkt_ok_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pkt_ok_q  <= 1'b0;
         pend_q    <= 1'b0;
         accept_o  <= 1'b0;
         discard_o <= 1'b0;
      end else if (vld_i) begin
         pkt_ok_q  <= pkt_ok_d;
         pend_q    <= pend_d;
         accept_o  <= acc_d;
         discard_o <= disc_d;
      end else begin
         accept_o  <= 1'b0;
         discard_o <= 1'b0;
      end
   end

endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk
   import blkseq_pkg::*;
#(
   parameter int CODE_W       = 3,
   parameter bit RELAXED_EXIT = 1'b1,
   parameter bit TAIL_STRICT  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              blk_vld_i,
   input  logic [CODE_W-1:0] blk_code_i,
   output logic [STATE_W-1:0] state_o,
   output logic              err_blk_o,
   output logic              accept_o,
   output logic              discard_o
);

   generate
      if (CODE_W < 3) begin : g_bad_width
         $error("blkseq_chk: CODE_W must be at least 3");
      end
   endgenerate

   seq_state_t cur_q, nxt;
   logic       prev_e_q;
   logic       e_twice;

   // Error lasted at least two blocks when the current one is seen.
   assign e_twice = (cur_q == ST_E) && prev_e_q;

   blkseq_next #(
      .CODE_W      (CODE_W),
      .RELAXED_EXIT(RELAXED_EXIT)
   ) u_next (
      .cur_i    (cur_q),
      .code_i   (blk_code_i),
      .e_twice_i(e_twice),
      .nxt_o    (nxt)
   );

   blkseq_pkt #(
      .TAIL_STRICT(TAIL_STRICT)
   ) u_pkt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (blk_vld_i),
      .cur_i    (cur_q),
      .nxt_i    (nxt),
      .accept_o (accept_o),
      .discard_o(discard_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q    <= ST_E;
         prev_e_q <= 1'b0;
      end else if (blk_vld_i) begin
         cur_q    <= nxt;
         prev_e_q <= (cur_q == ST_E);
      end
   end

   assign state_o   = cur_q;
   assign err_blk_o = (cur_q == ST_E);

endmodule

// File: rtl/blkseq_sva.sv
module blkseq_sva
   import blkseq_pkg::*;
#(
   parameter int CODE_W      = 3,
   parameter bit TAIL_STRICT = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              blk_vld_i,
   input logic [CODE_W-1:0] blk_code_i,
   input logic [STATE_W-1:0] state_o,
   input logic              err_blk_o,
   input logic              accept_o,
   input logic              discard_o
);

   localparam logic [STATE_W-1:0] SZ = 3'd0;
   localparam logic [STATE_W-1:0] SS = 3'd1;
   localparam logic [STATE_W-1:0] SD = 3'd2;
   localparam logic [STATE_W-1:0] ST = 3'd3;
   localparam logic [STATE_W-1:0] SE = 3'd4;

   // R2
   start_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_vld_i && state_o == SS) |=> (state_o == SD || state_o == SE));

   // R5
   fresh_err_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_vld_i && $rose(err_blk_o) && blk_code_i == CODE_W'(BK_START)) |=> (state_o == SE));

   // R7
   accept_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |-> (state_o == ST || (TAIL_STRICT && (state_o == SZ || state_o == SS))));

   // R8
   discard_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      discard_o |=> !discard_o);

   // R8
   discard_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      discard_o |-> err_blk_o);

   // R11
   hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blk_vld_i |=> ($stable(state_o) && !accept_o && !discard_o));

   // R7
   pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(accept_o && discard_o));

endmodule

bind blkseq_chk blkseq_sva #(
   .CODE_W     (CODE_W),
   .TAIL_STRICT(TAIL_STRICT)
) u_sva (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .blk_vld_i (blk_vld_i),
   .blk_code_i(blk_code_i),
   .state_o   (state_o),
   .err_blk_o (err_blk_o),
   .accept_o  (accept_o),
   .discard_o (discard_o)
);

// File: tb/blkseq_chk_test.sv
module blkseq_chk_test;

   localparam logic [2:0] CI = 3'd0, CS = 3'd1, CD = 3'd2, CT = 3'd3, CX = 3'd5;
   localparam int QZ = 0, QS = 1, QD = 2, QT = 3, QE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0;
   logic [2:0] code = CI;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [2:0] st_a, st_s, st_t;
   logic err_a, err_s, err_t;
   logic acc_a, acc_s, acc_t;
   logic dis_a, dis_s, dis_t;

   always #5 clk = ~clk;

   blkseq_chk uut (
      .clk_i(clk), .rst_ni(rst_n), .blk_vld_i(vld), .blk_code_i(code),
      .state_o(st_a), .err_blk_o(err_a), .accept_o(acc_a), .discard_o(dis_a));

   blkseq_chk #(.RELAXED_EXIT(1'b0)) uut_s (
      .clk_i(clk), .rst_ni(rst_n), .blk_vld_i(vld), .blk_code_i(code),
      .state_o(st_s), .err_blk_o(err_s), .accept_o(acc_s), .discard_o(dis_s));

   blkseq_chk #(.TAIL_STRICT(1'b1)) uut_t (
      .clk_i(clk), .rst_ni(rst_n), .blk_vld_i(vld), .blk_code_i(code),
      .state_o(st_t), .err_blk_o(err_t), .accept_o(acc_t), .discard_o(dis_t));

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   // Present one block; outputs are sampled just after the edge that takes it.
   task automatic step(input logic [2:0] c);
      @(negedge clk);
      vld  = 1'b1;
      code = c;
      @(posedge clk);
      #1;
   endtask

   task automatic sync_idle();
      step(CI);
      step(CI);
   endtask

   task automatic t_reset();
      chk("R1 state", st_a, QE);
      chk("R1 err_blk", err_a, 1);
      chk("R1 accept", acc_a, 0);
      chk("R1 discard", dis_a, 0);
      chk("R1 strict state", st_s, QE);
   endtask

   task automatic t_first_packet();
      step(CI);
      chk("R4 relaxed idle exit", st_a, QZ);
      chk("R6 strict idle exit", st_s, QZ);
      chk("R3 err_blk low", err_a, 0);
      step(CS); chk("R2 idle->start", st_a, QS);
      step(CD); chk("R2 start->data", st_a, QD);
      step(CD); chk("R2 data->data", st_a, QD);
      step(CT);
      chk("R2 data->term", st_a, QT);
      chk("R7 accept on term", acc_a, 1);
      chk("R12 no accept on term", acc_t, 0);
      step(CI);
      chk("R7 accept one cycle", acc_a, 0);
      chk("R12 late accept", acc_t, 1);
      chk("R2 term->idle", st_a, QZ);
   endtask

   task automatic t_back_to_back();
      sync_idle();
      step(CS); step(CD); step(CT);
      chk("R10 first accept", acc_a, 1);
      step(CS);
      chk("R10 term->start", st_a, QS);
      chk("R10 tail accept before start", acc_t, 1);
      step(CD); step(CT);
      chk("R10 second accept", acc_a, 1);
      step(CI);
      chk("R10 second tail accept", acc_t, 1);
   endtask

   task automatic t_illegal();
      sync_idle();
      step(CD);
      chk("R2 idle->data illegal", st_a, QE);
      chk("R3 err_blk high", err_a, 1);
      chk("R8 no discard outside packet", dis_a, 0);
      step(CI);
      step(CS);
      step(CS);
      chk("R2 start->start illegal", st_a, QE);
      chk("R8 discard on entry", dis_a, 1);
      step(CX);
      chk("R8 discard only once", dis_a, 0);
      chk("R8 still error", st_a, QE);
   endtask

   task automatic t_relaxed_exit();
      // machine is in error here after t_illegal
      step(CD);
      chk("R4 error->data", st_a, QD);
      chk("R6 strict stays on data", st_s, QE);
      step(CT);
      chk("R4 error->term path", st_a, QT);
      chk("R9 no accept after error", acc_a, 0);
      chk("R6 strict stays on term", st_s, QE);
      step(CI);
      chk("R6 strict idle exit", st_s, QZ);
   endtask

   task automatic t_forged_from_idle();
      sync_idle();
      step(CX);
      step(CS);
      chk("R5 fresh error blocks start", st_a, QE);
      step(CD);
      chk("R5 recover on data", st_a, QD);
      chk("R6 strict stays", st_s, QE);
      step(CT);
      chk("R9 idle,err,start,data rejected", acc_a, 0);
   endtask

   task automatic t_forged_from_term();
      sync_idle();
      step(CS); step(CD); step(CT);
      chk("R7 accept before tail error", acc_a, 1);
      step(CX);
      chk("R12 tail error discard", dis_t, 1);
      chk("R12 tail error no accept", acc_t, 0);
      chk("R8 lenient no discard after term", dis_a, 0);
      step(CS);
      chk("R5 start after term error blocked", st_a, QE);
      step(CD); step(CT);
      chk("R9 term,err,start,data rejected", acc_a, 0);
   endtask

   task automatic t_forged_from_data();
      sync_idle();
      step(CS); step(CD);
      step(CX);
      chk("R8 discard mid packet", dis_a, 1);
      step(CS);
      chk("R5 start after data error blocked", st_a, QE);
      step(CD); step(CT);
      chk("R9 data,err,start,data rejected", acc_a, 0);
   endtask

   task automatic t_double_error_start();
      sync_idle();
      step(CX);
      step(CX);
      step(CS);
      chk("R5 start after two errors", st_a, QS);
      chk("R6 strict rejects start", st_s, QE);
      step(CD); step(CT);
      chk("R5 packet after two errors accepted", acc_a, 1);
   endtask

   task automatic t_reset_start();
      // after a fresh reset, the first start is refused
      @(negedge clk);
      rst_n = 1'b0;
      vld   = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(CS);
      chk("R5 start after reset refused", st_a, QE);
      step(CS);
      chk("R5 second start taken", st_a, QS);
   endtask

   task automatic t_valid_low();
      sync_idle();
      step(CS);
      @(negedge clk);
      vld  = 1'b0;
      code = CX;
      repeat (3) @(posedge clk);
      #1;
      chk("R11 state held", st_a, QS);
      chk("R11 no discard", dis_a, 0);
      chk("R11 no accept", acc_a, 0);
      step(CD); step(CT);
      chk("R11 packet accepted after gap", acc_a, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_first_packet();
      t_back_to_back();
      t_illegal();
      t_relaxed_exit();
      t_forged_from_idle();
      t_forged_from_term();
      t_forged_from_data();
      t_double_error_start();
      t_reset_start();
      t_valid_low();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule